// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM that holds 64K words of 16 bits. It converts each accepted read or write into a sequence of active-low strobes: chip select, output enable, write enable and one strobe per byte lane. All strobes come straight from registers, so they carry no decode glitches. Each strobe is held for a whole number of clock cycles. That number is worked out at elaboration from the clock period and the speed grade of the memory, which is 55 ns or 70 ns.

A request carries an address, write data and a per-lane enable. The requester holds it until `req_ready` is high at a clock edge. A read returns one `rsp_valid` pulse with the word. Any byte lane that was not enabled reads back as zero. A request with no lane enabled completes at once and never selects the memory. The controller drives the shared data bus only while a write pulse is active. After a read it waits for the memory's output-release time before it may drive the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, with no request, chip select, output enable, write enable and both lane strobes are high, `mem_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for as long as chip select is low, and for the rest of the operation.
- R3: A read drives chip select low, output enable low, write enable high and `mem_bs_n = ~req_be` (bit 0 covers data bits 7:0, bit 1 covers bits 15:8). Address and lane strobes stay unchanged until the strobes are released.
- R4: For a read, the data is captured RDC+1 cycles after the accepting edge, with RDC = max(1, ceil(access time / CLK_PERIOD_NS)). The access time is 55 ns or 70 ns by grade. `rsp_valid` is high for the cycle that follows that edge.
- R5: In the returned word, every lane whose `req_be` bit was 0 reads as zero, whatever the bus carries on that lane.
- R6: A write drives chip select low, write enable low, output enable high, `mem_bs_n = ~req_be`, the address and the write data. All of these stay stable for the whole pulse. Only enabled lanes change in memory.
- R7: Write enable stays low for exactly WRC cycles. WRC is the largest of the ceiling cycle counts for the write pulse (45/55 ns), address-valid-to-end (50/60 ns) and data overlap (25/30 ns). Strobes, address and data are released on one edge, and `req_ready` returns WRC+1 cycles after the accepting edge.
- R8: `mem_dq_oe` is high only while write enable and chip select are low. It is never high while the memory could be driving the bus.
- R9: After a read releases its strobes, the controller waits at least TAC = ceil(max(output-release 20/25 ns, lane-release 25/30 ns) / period) cycles before it drives the bus. `req_ready` returns RDC+TAC+1 cycles after the read's accepting edge.
- R10: A request with `req_be = 2'b00` never lowers chip select and leaves `req_ready` high. As a read, it gives `rsp_valid` with a zero word in the cycle after acceptance. As a write, it leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Lane strobes, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
At the default 4 ns clock and 70 ns grade, RDC is 18, WRC is 15 and TAC is 8. So read data is due 19 cycles after the accepting edge, write readiness 16 cycles after it and read readiness 27 cycles after it. The bench sets inputs on falling edges and counts falling edges from the accepting edge. It compares each count with those same formulas, which it evaluates itself. Its memory model presents valid data only once the strobes have been steady for the access time, and it puts a non-zero pattern on unstrobed lanes. An early capture or a missing mask therefore gives a wrong word. The model also times every write pulse and every gap between a read release and a new bus drive in clock periods.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACC,
      ST_RD_CAP,
      ST_WR_PULSE,
      ST_WR_END,
      ST_TURN
   } sramc_state_e;

   // ceiling of ns / period, never below one cycle
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned t_access(input int unsigned grade);
      return (grade == 55) ? 55 : 70;
   endfunction

   function automatic int unsigned t_wpulse(input int unsigned grade);
      return (grade == 55) ? 45 : 55;
   endfunction

   function automatic int unsigned t_addr_end(input int unsigned grade);
      return (grade == 55) ? 50 : 60;
   endfunction

   function automatic int unsigned t_data_ovl(input int unsigned grade);
      return (grade == 55) ? 25 : 30;
   endfunction

   function automatic int unsigned t_oe_hz(input int unsigned grade);
      return (grade == 55) ? 20 : 25;
   endfunction

   function automatic int unsigned t_bs_hz(input int unsigned grade);
      return (grade == 55) ? 25 : 30;
   endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sramc_lane.sv
module sramc_lane #(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [LANE_W-1:0] wdata,
   input  logic              rd_cap,
   input  logic              rd_clr,
   input  logic              lane_en,
   input  logic [LANE_W-1:0] din,
   output logic [LANE_W-1:0] dq_o,
   output logic [LANE_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_o <= '0;
      end else if (wr_load) begin
         dq_o <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_cap) begin
         rdata <= lane_en ? din : '0;
      end else if (rd_clr) begin
         rdata <= '0;
      end
   end

   // R5: a lane without its strobe returns zero
   a_r5_lane_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cap && !lane_en) |=> (rdata == '0));

   // R6: write data held unless a new write is loaded
   a_r6_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_load |=> $stable(dq_o));

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
   import sramc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned LANES  = 2,
   parameter int unsigned RD_CYC = 18,
   parameter int unsigned WR_CYC = 15,
   parameter int unsigned TA_CYC = 8,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_be,
   output logic              req_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bs_n,
   output logic              mem_dq_oe,
   output logic              wr_load,
   output logic              rd_cap,
   output logic              rd_clr,
   output logic              rsp_valid
);

   sramc_state_e     state;
   logic             accept;
   logic             noop;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign noop      = (req_be == '0);
   assign wr_load   = accept && !noop && req_write;
   assign rd_clr    = accept && noop && !req_write;
   assign rd_cap    = (state == ST_RD_CAP);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (accept && !noop) begin
         tmr_load = 1'b1;
         tmr_val  = req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end else if (state == ST_RD_CAP) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(TA_CYC - 1);
      end
   end

   sramc_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_addr  <= '0;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_bs_n  <= '1;
         mem_dq_oe <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (noop) begin
                     rsp_valid <= !req_write;
                  end else if (req_write) begin
                     mem_addr  <= req_addr;
                     mem_ce_n  <= 1'b0;
                     mem_we_n  <= 1'b0;
                     mem_oe_n  <= 1'b1;
                     mem_bs_n  <= ~req_be;
                     mem_dq_oe <= 1'b1;
                     state     <= ST_WR_PULSE;
                  end else begin
                     mem_addr  <= req_addr;
                     mem_ce_n  <= 1'b0;
                     mem_oe_n  <= 1'b0;
                     mem_we_n  <= 1'b1;
                     mem_bs_n  <= ~req_be;
                     state     <= ST_RD_ACC;
                  end
               end
            end
            ST_RD_ACC: begin
               if (tmr_zero) state <= ST_RD_CAP;
            end
            ST_RD_CAP: begin
               mem_ce_n  <= 1'b1;
               mem_oe_n  <= 1'b1;
               mem_bs_n  <= '1;
               rsp_valid <= 1'b1;
               state     <= ST_TURN;
            end
            ST_TURN: begin
               if (tmr_zero) state <= ST_IDLE;
            end
            ST_WR_PULSE: begin
               if (tmr_zero) begin
                  mem_we_n  <= 1'b1;
                  mem_ce_n  <= 1'b1;
                  mem_bs_n  <= '1;
                  mem_dq_oe <= 1'b0;
                  state     <= ST_WR_END;
               end
            end
            ST_WR_END: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // window counters observed by the properties below
   logic [CNT_W-1:0] we_len;
   logic [CNT_W-1:0] ta_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_len <= '0;
         ta_len <= CNT_W'(TA_CYC);
      end else begin
         we_len <= mem_we_n ? '0 : we_len + 1'b1;
         if (!mem_ce_n && !mem_oe_n) ta_len <= '0;
         else if (ta_len != CNT_W'(TA_CYC)) ta_len <= ta_len + 1'b1;
      end
   end

   // R1: standby keeps every strobe released
   a_r1_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_bs_n == '1 && mem_oe_n && mem_we_n && !mem_dq_oe));

   // R2: no new request while the memory is selected
   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   // R3: read address and strobes do not move mid-access
   a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !mem_oe_n && $past(!mem_ce_n && !mem_oe_n)) |->
      ($stable(mem_addr) && $stable(mem_bs_n)));

   // R6: write address and strobes do not move mid-pulse
   a_r6_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_bs_n) && !mem_ce_n));

   // R7: the write pulse lasts exactly the counted minimum
   a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_len == CNT_W'(WR_CYC)));

   // R8: the bus is driven only inside a write pulse
   a_r8_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

   // R9: release time respected before driving
   a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (ta_len >= CNT_W'(TA_CYC)));

   // R10: an all-disabled request never selects the memory
   a_r10_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && noop) |=> (mem_ce_n && req_ready));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sramc_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned SPEED_GRADE   = 70
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_be,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_ce_n,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic [DATA_W/8-1:0] mem_bs_n,
   output logic [DATA_W-1:0]   mem_dq_o,
   output logic                mem_dq_oe,
   input  logic [DATA_W-1:0]   mem_dq_i
);

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned RD_CYC = ns_to_cyc(t_access(SPEED_GRADE), CLK_PERIOD_NS);
   localparam int unsigned WR_CYC = max2(max2(ns_to_cyc(t_wpulse(SPEED_GRADE), CLK_PERIOD_NS),
                                              ns_to_cyc(t_addr_end(SPEED_GRADE), CLK_PERIOD_NS)),
                                         ns_to_cyc(t_data_ovl(SPEED_GRADE), CLK_PERIOD_NS));
   localparam int unsigned TA_CYC = max2(ns_to_cyc(t_oe_hz(SPEED_GRADE), CLK_PERIOD_NS),
                                         ns_to_cyc(t_bs_hz(SPEED_GRADE), CLK_PERIOD_NS));
   localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WR_CYC), TA_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (SPEED_GRADE != 55 && SPEED_GRADE != 70) begin : g_bad_grade
      $error("SPEED_GRADE must be 55 or 70");
   end
   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be non-zero");
   end

   logic wr_load;
   logic rd_cap;
   logic rd_clr;

   sramc_fsm #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .RD_CYC (RD_CYC),
      .WR_CYC (WR_CYC),
      .TA_CYC (TA_CYC),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_ready (req_ready),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_bs_n  (mem_bs_n),
      .mem_dq_oe (mem_dq_oe),
      .wr_load   (wr_load),
      .rd_cap    (rd_cap),
      .rd_clr    (rd_clr),
      .rsp_valid (rsp_valid)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sramc_lane #(.LANE_W(8)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_load (wr_load),
         .wdata   (req_wdata[g*8 +: 8]),
         .rd_cap  (rd_cap),
         .rd_clr  (rd_clr),
         .lane_en (!mem_bs_n[g]),
         .din     (mem_dq_i[g*8 +: 8]),
         .dq_o    (mem_dq_o[g*8 +: 8]),
         .rdata   (rsp_rdata[g*8 +: 8])
      );
   end

   // R4: a read response only follows a capture or an all-disabled read
   a_r4_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(rd_cap) || $past(rd_clr)));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

   localparam int P     = 4;
   localparam int GRADE = 70;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + P - 1) / P;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int T_AA  = (GRADE == 55) ? 55 : 70;
   localparam int T_WP  = (GRADE == 55) ? 45 : 55;
   localparam int T_AW  = (GRADE == 55) ? 50 : 60;
   localparam int T_DW  = (GRADE == 55) ? 25 : 30;
   localparam int T_HZ  = (GRADE == 55) ? 25 : 30;
   localparam int RDC   = cdiv(T_AA);
   localparam int WRC   = imax(imax(cdiv(T_WP), cdiv(T_AW)), cdiv(T_DW));
   localparam int TAC   = imax(cdiv((GRADE == 55) ? 20 : 25), cdiv(T_HZ));

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [15:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n;
   logic [1:0]  mem_bs_n;
   logic [15:0] mem_dq_o;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_i = 16'hEEEE;

   int n_cmp = 0;
   int n_bad = 0;

   always #(P/2) clk = ~clk;

   sram_lane_ctrl #(.CLK_PERIOD_NS(P), .SPEED_GRADE(GRADE)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // ---------------- memory model ----------------
   logic [15:0] mdl [int];
   logic [15:0] refm [int];
   int  cyc_idx = 0;
   int  rd_run = 0;
   int  wr_run = 0;
   int  rel_idx = -1000;
   bit  drv = 0;
   bit  prev_oe = 0;
   int  ce_low = 0;
   logic [15:0] l_addr, l_data;
   logic [1:0]  l_bs;

   function automatic logic [15:0] mrd(input logic [15:0] a);
      return mdl.exists(int'(a)) ? mdl[int'(a)] : 16'h0000;
   endfunction

   always @(negedge clk) begin
      logic rd_c, wr_c;
      logic [15:0] w, v;
      cyc_idx++;
      if (!mem_ce_n) ce_low++;
      rd_c = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n && (mem_bs_n != 2'b11);
      wr_c = rst_n && !mem_ce_n && !mem_we_n;
      if (rd_c) begin
         if (rd_run > 0 && mem_addr == l_addr && mem_bs_n == l_bs) rd_run++;
         else rd_run = 1;
         l_addr = mem_addr; l_bs = mem_bs_n; drv = 1;
         w = mrd(mem_addr);
         for (int l = 0; l < 2; l++) begin
            if (mem_bs_n[l]) v[l*8 +: 8] = 8'hEE;
            else if (rd_run * P >= T_AA) v[l*8 +: 8] = w[l*8 +: 8];
            else v[l*8 +: 8] = 8'h5A;
         end
         mem_dq_i <= v;
         if (mem_dq_oe) chk("R8", "bus contention", 1, 0);
      end else begin
         rd_run = 0;
         if (drv) begin rel_idx = cyc_idx; drv = 0; end
         mem_dq_i <= 16'hEEEE;
      end
      if (mem_dq_oe && !prev_oe && (cyc_idx - rel_idx) * P < T_HZ)
         chk("R9", "drive before release time", (cyc_idx - rel_idx) * P, T_HZ);
      prev_oe = mem_dq_oe;
      if (wr_c) begin
         if (wr_run == 0) begin
            l_addr = mem_addr; l_data = mem_dq_o; l_bs = mem_bs_n;
         end else if (mem_addr != l_addr || mem_dq_o != l_data || mem_bs_n != l_bs || !mem_dq_oe || !mem_oe_n) begin
            chk("R6", "write signals moved", 1, 0);
         end
         wr_run++;
      end else if (wr_run > 0) begin
         if (wr_run * P < T_WP || wr_run * P < T_AW || wr_run * P < T_DW)
            chk("R7", "write pulse too short ns", wr_run * P, T_AW);
         w = mrd(l_addr);
         for (int l = 0; l < 2; l++)
            if (!l_bs[l]) w[l*8 +: 8] = l_data[l*8 +: 8];
         mdl[int'(l_addr)] = w;
         wr_run = 0;
      end
   end

   function automatic logic [15:0] rref(input logic [15:0] a);
      return refm.exists(int'(a)) ? refm[int'(a)] : 16'h0000;
   endfunction

   // ---------------- request tasks ----------------
   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
      int k;
      logic [15:0] w;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      k = 0;
      if (be != 0) chk("R2", "ready low during write", int'(req_ready), 0);
      while (!req_ready && k < 1000) begin @(negedge clk); k++; end
      chk("R7", "write ready latency", k, (be == 0) ? 0 : WRC + 1);
      w = rref(a);
      for (int l = 0; l < 2; l++) if (be[l]) w[l*8 +: 8] = d[l*8 +: 8];
      refm[int'(a)] = w;
   endtask

   task automatic do_read(input logic [15:0] a, input logic [1:0] be, input string tag);
      int k, rk;
      logic [15:0] got, exp;
      bit seen;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_be = be;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      if (be != 0)
         chk("R3", "read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, {3'b001, ~be});
      k = 0; rk = -1; seen = 0; got = 0;
      while (k < 1000) begin
         if (rsp_valid && !seen) begin seen = 1; rk = k; got = rsp_rdata; end
         if (seen && req_ready) break;
         @(negedge clk); k++;
      end
      exp = rref(a);
      for (int l = 0; l < 2; l++) if (!be[l]) exp[l*8 +: 8] = 8'h00;
      chk("R4", "response latency", rk, (be == 0) ? 0 : RDC + 1);
      chk(tag, "read data", got, exp);
      if (be != 0) chk("R9", "read ready latency", k, RDC + TAC + 1);
   endtask

   // ---------------- scenarios ----------------
   task automatic sc_reset();
      chk("R1", "strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}, 6'b111110);
      @(negedge clk); rst_n = 1;
      repeat (3) @(negedge clk);
      chk("R1", "strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}, 6'b111110);
      chk("R1", "ready/rsp after reset", {req_ready, rsp_valid}, 2'b10);
   endtask

   task automatic sc_full_word();
      do_write(16'h0010, 16'h1234, 2'b11);
      do_read(16'h0010, 2'b11, "R3");
      do_write(16'hFFFF, 16'hBEEF, 2'b11);
      do_read(16'hFFFF, 2'b11, "R6");
   endtask

   task automatic sc_lanes();
      do_write(16'h0020, 16'hAAAA, 2'b11);
      do_write(16'h0020, 16'h5511, 2'b01);
      do_read(16'h0020, 2'b11, "R6");
      do_write(16'h0020, 16'h77CC, 2'b10);
      do_read(16'h0020, 2'b01, "R5");
      do_read(16'h0020, 2'b10, "R5");
   endtask

   task automatic sc_noop();
      int c0;
      do_write(16'h0030, 16'h4321, 2'b11);
      c0 = ce_low;
      do_write(16'h0030, 16'hFFFF, 2'b00);
      do_read(16'h0030, 2'b00, "R10");
      chk("R10", "no chip select on no-op", ce_low - c0, 0);
      do_read(16'h0030, 2'b11, "R10");
   endtask

   task automatic sc_b2b();
      int k;
      do_write(16'h0040, 16'h0F0F, 2'b11);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 16'h0040; req_be = 2'b11;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_write = 1; req_wdata = 16'hC3C3;
      k = 0;
      while (mem_we_n && k < 1000) begin @(negedge clk); k++; end
      req_valid = 0;
      chk("R9", "write waits for turnaround", k, RDC + TAC + 2);
      while (!req_ready) @(negedge clk);
      refm[16'h0040] = 16'hC3C3;
      do_read(16'h0040, 2'b11, "R2");
   endtask

   task automatic sc_random();
      for (int i = 0; i < 40; i++) begin
         logic [15:0] a;
         logic [1:0]  be;
         a  = {12'h3C0, 4'($urandom_range(0, 15))};
         be = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom), be);
         else do_read(a, be, "R5");
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      sc_reset();
      sc_full_word();
      sc_lanes();
      sc_noop();
      sc_b2b();
      sc_random();
      repeat (4) @(negedge clk);
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule